// File: doc/BRIEF.md
# Receive FIFO with Threshold-Driven Flow Control

This block buffers bytes arriving from a serial receiver in a 16-entry first-in first-out store. A deserializer hands it one byte per push strobe; the processor takes bytes off the head with a pop strobe. The byte at the head is always visible on the read data port, so a pop consumes the value shown in the same cycle.

A 16-bit control register can be read and written by the processor in any cycle. It holds two coded fill thresholds. The first sets a "receive data ready" flag once the store holds at least a chosen number of bytes. The second drives a request-to-send line high once the fill count goes past a separate chosen number, so that the far end stops sending. The register also holds a hold-clear bit for the receive store, a hold-clear bit for the transmit side's byte count, and a loopback enable. The last two are only exported to the neighbouring transmit and serial logic. A sticky overrun bit records any byte that was lost because the store was full.

Both flags are formed directly from the registered fill count and the registered threshold codes. They therefore change in the cycle after the count or the code changes.

Top module: `rx_fifo_trig_top`

## Requirements
- R1: After reset the register reads 0x0000, the fill count is 0, and the ready flag, request-to-send line, loopback output and transmit-clear output are all low.
- R2: Register bits 15:11 and 5:4 always read 0, whatever was written to them.
- R3: The register can be written in any cycle. From the next cycle, bits 10:8 read back the request-to-send code, bits 7:6 the ready code, and bits 2:0 the transmit-clear, receive-clear and loopback bits (bit 2, bit 1, bit 0).
- R4: Code 000 in bits 10:8 selects a request-to-send level of 15. Codes 001 to 111 select 1, 4, 6, 8, 10, 12 and 14. The request-to-send line is high exactly when the fill count is greater than the selected level.
- R5: Code 00 in bits 7:6 selects a ready level of 1; codes 01, 10 and 11 select 4, 8 and 14. The ready flag is high exactly when the fill count is equal to or greater than the selected level.
- R6: Bytes leave in the order they were stored. The head byte is shown on the pop data port, a push adds one to the count and a pop subtracts one.
- R7: A push while the store holds 16 bytes without a pop in that cycle is dropped, and it sets overrun bit 3 of the register. Bit 3 stays set until a write with bit 3 equal to 1 clears it. If a drop and such a write fall in the same cycle, the bit stays set.
- R8: A pop while the store is empty leaves the count at 0, and the pop data port shows 0 while the store is empty.
- R9: A push and a pop in the same cycle on a non-empty store, full included, leave the count unchanged, keep the order and set no overrun.
- R10: While register bit 1 is 1, the fill count is forced to 0 from the next cycle on and pushes are not stored.
- R11: The loopback output follows register bit 0, and the transmit-clear output follows register bit 2.
- R12: The ready flag and the request-to-send line reflect a new count or a new threshold code in the cycle after the push, pop or register write that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or manual) |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 16 | Control register write value |
| reg_rd_data | output | 16 | Control register read value |
| push_valid | input | 1 | Store one received byte |
| push_data | input | 8 | Received byte |
| pop_req | input | 1 | Remove the head byte |
| pop_data | output | 8 | Head byte, 0 when empty |
| fill_count | output | 5 | Bytes held, 0 to 16 |
| rdf_flag | output | 1 | Receive data ready flag |
| rts_level | output | 1 | Request-to-send line level |
| loopback_en | output | 1 | Loopback enable for the serial datapath |
| tx_count_clr | output | 1 | Hold-clear for the transmit byte count |

## Verification
A wrong pointer or count shows up on the pop data port as a byte out of order, and it shows on the fill count one cycle after the push or pop that corrupted it. Threshold decoding errors show up as the ready flag or the request-to-send line toggling one byte early or late. The bench sweeps every code over fills from 0 to 16, so such an error is visible in the cycle after the fill that crosses the level. A lost or stuck overrun bit can be read back through bit 3 of the register in the cycle after the dropped push or the clearing write.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int LVL_W = 8;

    typedef struct packed {
        logic [2:0] rts_code;
        logic [1:0] rdf_code;
        logic       tx_clr;
        logic       rx_clr;
        logic       loopback;
    } ctrl_t;

    function automatic logic [LVL_W-1:0] rdf_threshold(input logic [1:0] code);
        logic [LVL_W-1:0] lvl;
        case (code)
            2'b00:   lvl = LVL_W'(1);
            2'b01:   lvl = LVL_W'(4);
            2'b10:   lvl = LVL_W'(8);
            default: lvl = LVL_W'(14);
        endcase
        return lvl;
    endfunction

    function automatic logic [LVL_W-1:0] rts_threshold(input logic [2:0] code);
        logic [LVL_W-1:0] lvl;
        if (code == 3'b000) begin
            lvl = LVL_W'(15);
        end else if (code == 3'b001) begin
            lvl = LVL_W'(1);
        end else begin
            lvl = LVL_W'({code, 1'b0} - 4'd0);
        end
        return lvl;
    endfunction

endpackage

// File: rtl/rxf_ctrl_reg.sv
module rxf_ctrl_reg
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [15:0] wr_data_i,
    input  logic        ovr_i,
    output ctrl_t       ctrl_o,
    output logic        ovr_clr_o,
    output logic [15:0] rd_data_o
);

    typedef struct packed {
        ctrl_t ctrl;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.ctrl.rts_code = wr_data_i[10:8];
            st_d.ctrl.rdf_code = wr_data_i[7:6];
            st_d.ctrl.tx_clr   = wr_data_i[2];
            st_d.ctrl.rx_clr   = wr_data_i[1];
            st_d.ctrl.loopback = wr_data_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o    = st_q.ctrl;
    assign ovr_clr_o = wr_en_i & wr_data_i[3];
    assign rd_data_o = {5'b0, st_q.ctrl.rts_code, st_q.ctrl.rdf_code, 2'b0,
                        ovr_i, st_q.ctrl.tx_clr, st_q.ctrl.rx_clr, st_q.ctrl.loopback};

    // R3: a written code is what the register holds one cycle later
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (ctrl_o.rts_code == $past(wr_data_i[10:8]))
                 && (ctrl_o.rdf_code == $past(wr_data_i[7:6])));

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic              clr_i,
    input  logic              ovr_clr_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovr_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic is_full, is_empty, pop_ok, push_ok, drop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        is_full  = (st_q.cnt == CNT_W'(DEPTH));
        is_empty = (st_q.cnt == '0);
        pop_ok   = pop_i && !clr_i && !is_empty;
        push_ok  = push_i && !clr_i && (!is_full || pop_ok);
        drop     = push_i && !clr_i && is_full && !pop_ok;

        st_d = st_q;
        if (clr_i) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
        end else begin
            if (push_ok) st_d.wr_ptr = ptr_next(st_q.wr_ptr);
            if (pop_ok)  st_d.rd_ptr = ptr_next(st_q.rd_ptr);
            if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
            else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
        end
        if (drop)           st_d.ovr = 1'b1;
        else if (ovr_clr_i) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr_ptr] <= push_data_i;
    end

    assign head_o = is_empty ? '0 : mem_q[st_q.rd_ptr];
    assign cnt_o  = st_q.cnt;
    assign ovr_o  = st_q.ovr;

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_W'(DEPTH));

    p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !clr_i && cnt_o == CNT_W'(DEPTH)) |=> (cnt_o == CNT_W'(DEPTH)) && ovr_o);

    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !clr_i && cnt_o == '0) |=> (cnt_o == '0));

    p_pushpop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !clr_i && cnt_o != '0) |=> $stable(cnt_o));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/rxf_level_detect.sv
module rxf_level_detect
    import rxf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [1:0]       rdf_code_i,
    input  logic [2:0]       rts_code_i,
    output logic             rdf_o,
    output logic             rts_o
);

    logic [LVL_W-1:0] cnt_ext;

    always_comb begin
        cnt_ext = LVL_W'(cnt_i);
        rdf_o   = (cnt_ext >= rdf_threshold(rdf_code_i));
        rts_o   = (cnt_ext >  rts_threshold(rts_code_i));
    end

endmodule

// File: rtl/rx_fifo_trig_top.sv
module rx_fifo_trig_top
    import rxf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [15:0]       reg_wr_data,
    output logic [15:0]       reg_rd_data,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  fill_count,
    output logic              rdf_flag,
    output logic              rts_level,
    output logic              loopback_en,
    output logic              tx_count_clr
);

    ctrl_t ctrl;
    logic  ovr_clr, ovr;

    rxf_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .wr_data_i (reg_wr_data),
        .ovr_i     (ovr),
        .ctrl_o    (ctrl),
        .ovr_clr_o (ovr_clr),
        .rd_data_o (reg_rd_data)
    );

    rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_valid),
        .push_data_i (push_data),
        .pop_i       (pop_req),
        .clr_i       (ctrl.rx_clr),
        .ovr_clr_i   (ovr_clr),
        .head_o      (pop_data),
        .cnt_o       (fill_count),
        .ovr_o       (ovr)
    );

    rxf_level_detect #(.CNT_W(CNT_W)) u_lvl (
        .cnt_i      (fill_count),
        .rdf_code_i (ctrl.rdf_code),
        .rts_code_i (ctrl.rts_code),
        .rdf_o      (rdf_flag),
        .rts_o      (rts_level)
    );

    assign loopback_en  = ctrl.loopback;
    assign tx_count_clr = ctrl.tx_clr;

    // R4/R5: a full store exceeds every level of both tables
    p_full_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CNT_W'(DEPTH)) |-> (rts_level && rdf_flag));

    p_empty_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> (!rts_level && !rdf_flag));

endmodule

// File: tb/rx_fifo_trig_top_tb_top.sv
module rx_fifo_trig_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] reg_rd_data;
    logic        push_valid = 1'b0;
    logic [7:0]  push_data = '0;
    logic        pop_req = 1'b0;
    logic [7:0]  pop_data;
    logic [4:0]  fill_count;
    logic        rdf_flag, rts_level, loopback_en, tx_count_clr;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] ctl_sh = '0;
    logic [7:0]  model[$];

    always #10 clk = ~clk;

    rx_fifo_trig_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .push_valid(push_valid), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data),
        .fill_count(fill_count), .rdf_flag(rdf_flag), .rts_level(rts_level),
        .loopback_en(loopback_en), .tx_count_clr(tx_count_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rdf_lvl(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int rts_lvl(input int code);
        case (code)
            0: return 15;
            1: return 1;
            2: return 4;
            3: return 6;
            4: return 8;
            5: return 10;
            6: return 12;
            default: return 14;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        reg_wr_en = 1'b1;
        reg_wr_data = v;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        push_valid = 1'b1;
        push_data = b;
        step();
        push_valid = 1'b0;
        if (model.size() < 16) model.push_back(b);
    endtask

    task automatic pop_chk(input string req);
        chk(req, pop_data, (model.size() != 0) ? int'(model[0]) : 0);
        pop_req = 1'b1;
        step();
        pop_req = 1'b0;
        if (model.size() != 0) void'(model.pop_front());
    endtask

    task automatic flush();
        wr(ctl_sh | 16'h0002);
        wr(ctl_sh);
        model.delete();
    endtask

    task automatic t_reset();
        chk("R1 reg", reg_rd_data, 0);
        chk("R1 count", fill_count, 0);
        chk("R1 rdf", rdf_flag, 0);
        chk("R1 rts", rts_level, 0);
        chk("R1 loopback", loopback_en, 0);
        chk("R1 txclr", tx_count_clr, 0);
    endtask

    task automatic t_reg_fields();
        wr(16'hFFFF);
        chk("R2 reserved read", reg_rd_data, 16'h07C7);
        chk("R11 loopback", loopback_en, 1);
        chk("R11 txclr", tx_count_clr, 1);
        wr(16'h0541);
        chk("R3 readback", reg_rd_data, 16'h0541);
        chk("R11 txclr low", tx_count_clr, 0);
        wr(16'h0004);
        chk("R11 txclr only", tx_count_clr, 1);
        chk("R11 loopback low", loopback_en, 0);
        ctl_sh = 16'h0000;
        wr(ctl_sh);
    endtask

    task automatic t_rdf_sweep();
        for (int c = 0; c < 4; c++) begin
            ctl_sh = 16'(c << 6);
            flush();
            chk("R5 rdf empty", rdf_flag, 0);
            for (int k = 1; k <= 16; k++) begin
                push(8'(k));
                chk("R5 R12 rdf level", rdf_flag, (k >= rdf_lvl(c)) ? 1 : 0);
            end
        end
    endtask

    task automatic t_rts_sweep();
        for (int c = 0; c < 8; c++) begin
            ctl_sh = 16'(c << 8);
            flush();
            chk("R4 rts empty", rts_level, 0);
            for (int k = 1; k <= 16; k++) begin
                push(8'(k + 40));
                chk("R4 R12 rts level", rts_level, (k > rts_lvl(c)) ? 1 : 0);
            end
        end
    endtask

    task automatic t_code_change();
        ctl_sh = 16'h0000;
        flush();
        for (int k = 0; k < 5; k++) push(8'(k));
        chk("R4 rts lvl15 at 5", rts_level, 0);
        ctl_sh = 16'h0100;
        wr(ctl_sh);
        chk("R12 rts after code 001", rts_level, 1);
        ctl_sh = 16'h0400;
        wr(ctl_sh);
        chk("R12 rts after code 100", rts_level, 0);
        ctl_sh = 16'h00C0;
        wr(ctl_sh);
        chk("R12 rdf after code 11", rdf_flag, 0);
        ctl_sh = 16'h0040;
        wr(ctl_sh);
        chk("R12 rdf after code 01", rdf_flag, 1);
    endtask

    task automatic t_order();
        ctl_sh = 16'h0000;
        flush();
        push(8'hA1); push(8'hB2); push(8'hC3);
        chk("R6 count up", fill_count, 3);
        pop_chk("R6 order");
        chk("R6 count down", fill_count, 2);
        pop_chk("R6 order");
        pop_chk("R6 order");
        chk("R6 drained", fill_count, 0);
    endtask

    task automatic t_empty_pop();
        flush();
        chk("R8 empty data", pop_data, 0);
        pop_chk("R8 empty pop data");
        chk("R8 count stays", fill_count, 0);
    endtask

    task automatic t_pushpop();
        flush();
        push(8'h10); push(8'h20);
        chk("R9 head", pop_data, 8'h10);
        push_valid = 1'b1; push_data = 8'h30; pop_req = 1'b1;
        step();
        push_valid = 1'b0; pop_req = 1'b0;
        void'(model.pop_front()); model.push_back(8'h30);
        chk("R9 count same", fill_count, 2);
        pop_chk("R9 order");
        pop_chk("R9 order");
    endtask

    task automatic t_full_overrun();
        flush();
        for (int k = 0; k < 16; k++) push(8'(k * 3 + 1));
        chk("R7 full", fill_count, 16);
        push(8'hEE);
        chk("R7 drop count", fill_count, 16);
        chk("R7 overrun set", reg_rd_data[3], 1);
        wr(ctl_sh | 16'h0008);
        chk("R7 overrun cleared", reg_rd_data[3], 0);
        push_valid = 1'b1; push_data = 8'hEF;
        reg_wr_en = 1'b1; reg_wr_data = ctl_sh | 16'h0008;
        step();
        push_valid = 1'b0; reg_wr_en = 1'b0;
        chk("R7 set wins", reg_rd_data[3], 1);
        wr(ctl_sh | 16'h0008);
        chk("R9 head full", pop_data, model[0]);
        push_valid = 1'b1; push_data = 8'h77; pop_req = 1'b1;
        step();
        push_valid = 1'b0; pop_req = 1'b0;
        void'(model.pop_front()); model.push_back(8'h77);
        chk("R9 full count same", fill_count, 16);
        chk("R9 no overrun", reg_rd_data[3], 0);
        for (int k = 0; k < 16; k++) pop_chk("R6 R7 full order");
        chk("R6 emptied", fill_count, 0);
    endtask

    task automatic t_clear();
        flush();
        push(8'h01); push(8'h02); push(8'h03);
        wr(ctl_sh | 16'h0002);
        chk("R10 not yet", fill_count, 3);
        step();
        chk("R10 cleared", fill_count, 0);
        push_valid = 1'b1; push_data = 8'h55;
        step();
        push_valid = 1'b0;
        chk("R10 push ignored", fill_count, 0);
        chk("R10 data zero", pop_data, 0);
        wr(ctl_sh);
        model.delete();
        push(8'h66);
        chk("R10 resumes", fill_count, 1);
        pop_chk("R10 after clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_fields();
        t_order();
        t_empty_pop();
        t_pushpop();
        t_rdf_sweep();
        t_rts_sweep();
        t_code_change();
        t_full_overrun();
        t_clear();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule